// File: doc/BRIEF.md
# PLL Fine Phase-Step Sequencer

This controller moves the phase of a PLL output clock by a requested number of fine increments. Each increment is one eighth of the VCO period. For example, 40 increments with a 1000 MHz VCO move a 100 MHz output by 5 ns, which is half of its period. The user side loads a step count, a direction bit and a counter-select code with a one-cycle start request. While the run is in progress a busy flag is high, and a one-cycle complete flag marks the end of the run.

On the PLL side, the block raises a step request and holds it for two scan-clock cycles. The PLL samples that request on the falling scan-clock edge. The block keeps direction and counter-select steady for the whole run, because the PLL captures them two rising edges after it latches the request. The PLL then pulls its done line low, and the block waits until done has gone low and come back high before it sends the next request.

The low time of done can be much shorter than a scan-clock cycle. A flop set asynchronously by the falling edge of done therefore records that the low phase happened. A programmable cycle limit flags an error when the handshake does not finish in time. All other logic runs on the rising scan-clock edge, so the step request changes half a cycle before the PLL samples it.

Top module: `phase_step_seq`

## Requirements
- R1: After reset, busy_o, complete_o, error_o and step_o are all 0.
- R2: A start_i in idle with steps_i = N > 0 produces exactly N step pulses. busy_o is 1 from the cycle after start until the run ends. In the last cycle, busy_o is 0 and complete_o is 1 for exactly one cycle.
- R3: Each step pulse on step_o lasts exactly two clock cycles.
- R4: step_o stays low for at least one cycle between pulses. No new pulse starts until done_i has fallen and then returned high.
- R5: updown_o and cntsel_o equal the dir_i and sel_i values captured at start, and they stay stable while busy_o is 1.
- R6: A done_i low pulse shorter than half a clock cycle is still recognised as a completed step.
- R7: If the done handshake does not finish within timeout_i+1 cycles of waiting, error_o is set, busy_o drops and no complete pulse occurs. error_o clears on the next accepted start.
- R8: start_i while busy_o is 1 is ignored; the run in progress neither restarts nor changes its count.
- R9: start_i with steps_i = 0 gives complete_o = 1 in the next cycle, with no step pulse and busy_o staying 0.
- R10: A start_i asserted in the cycle where complete_o is 1 is accepted and begins a new run immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all sequencing uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a run (accepted only when idle) |
| steps_i | input | CW | Number of phase steps to apply |
| dir_i | input | 1 | Shift direction, 1 = up |
| sel_i | input | SW | Output counter select code |
| timeout_i | input | TW | Handshake wait limit in cycles |
| busy_o | output | 1 | Run in progress |
| complete_o | output | 1 | One-cycle pulse when a run ends normally |
| error_o | output | 1 | Handshake timeout seen in the last run |
| step_o | output | 1 | Phase step request to the PLL |
| updown_o | output | 1 | Direction to the PLL |
| cntsel_o | output | SW | Counter select to the PLL |
| done_i | input | 1 | Step finished indication from the PLL |

## Verification
The end of one run and the start of the next can fall in the same cycle. A run finishes by dropping busy and pulsing complete, and the start request is sampled in that very cycle. The bench drives start_i during the cycle in which it observes complete_o high. It expects the new run to be accepted, shown by busy_o returning high one cycle later, and it expects the PLL model to count the steps of both runs together, with the new direction and select captured for the second run.

// File: rtl/phase_step_seq.sv
module phase_step_seq #(
  parameter int CW = 8,
  parameter int SW = 4,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [CW-1:0] steps_i,
  input  logic          dir_i,
  input  logic [SW-1:0] sel_i,
  input  logic [TW-1:0] timeout_i,
  output logic          busy_o,
  output logic          complete_o,
  output logic          error_o,
  output logic          step_o,
  output logic          updown_o,
  output logic [SW-1:0] cntsel_o,
  input  logic          done_i
);
  typedef enum logic [1:0] {IDLE, STEP, WAIT, REST} st_t;

  st_t           st;
  logic          phc, arm_q, low_seen;
  logic [1:0]    low_sync, done_sync;
  logic [CW-1:0] left;
  logic [TW-1:0] timer;

  wire handshake_ok = low_sync[1] & done_sync[1];

  assign busy_o = (st != IDLE);
  assign step_o = (st == STEP);

  always_ff @(negedge done_i or negedge arm_q)
    if (!arm_q) low_seen <= 1'b0;
    else        low_seen <= 1'b1;

  always_ff @(posedge clk) begin
    done_sync <= {done_sync[0], done_i};
    if (!arm_q) low_sync <= '0;
    else        low_sync <= {low_sync[0], low_seen};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= IDLE;
      phc        <= 1'b0;
      arm_q      <= 1'b0;
      left       <= '0;
      timer      <= '0;
      complete_o <= 1'b0;
      error_o    <= 1'b0;
      updown_o   <= 1'b0;
      cntsel_o   <= '0;
    end else begin
      complete_o <= 1'b0;
      case (st)
        IDLE: if (start_i) begin
          updown_o <= dir_i;
          cntsel_o <= sel_i;
          error_o  <= 1'b0;
          if (steps_i == '0) complete_o <= 1'b1;
          else begin
            left <= steps_i;
            phc  <= 1'b0;
            st   <= STEP;
          end
        end
        STEP: begin
          phc <= 1'b1;
          if (!phc) arm_q <= 1'b1;
          else begin
            timer <= '0;
            st    <= WAIT;
          end
        end
        WAIT: begin
          if (handshake_ok) begin
            arm_q <= 1'b0;
            left  <= left - 1'b1;
            if (left == CW'(1)) begin
              complete_o <= 1'b1;
              st         <= IDLE;
            end else st <= REST;
          end else if (timer == timeout_i) begin
            arm_q   <= 1'b0;
            error_o <= 1'b1;
            st      <= IDLE;
          end else timer <= timer + 1'b1;
        end
        default: begin
          phc <= 1'b0;
          st  <= STEP;
        end
      endcase
    end
  end
endmodule

module phase_step_seq_chk #(
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_o,
  input logic          complete_o,
  input logic          error_o,
  input logic          step_o,
  input logic          updown_o,
  input logic [SW-1:0] cntsel_o
);
  assert_step_held_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(step_o) |=> step_o);
  assert_step_not_over_two_R3: assert property (@(posedge clk) disable iff (rst)
    (step_o && $past(step_o)) |=> !step_o);
  assert_step_gap_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(step_o) |=> !step_o);
  assert_step_inside_run_R2: assert property (@(posedge clk) disable iff (rst)
    step_o |-> busy_o);
  assert_complete_after_busy_R2: assert property (@(posedge clk) disable iff (rst)
    complete_o |-> !busy_o);
  assert_controls_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(updown_o) && $stable(cntsel_o)));
  assert_no_complete_on_error_R7: assert property (@(posedge clk) disable iff (rst)
    complete_o |-> !error_o);
endmodule

bind phase_step_seq phase_step_seq_chk #(.SW(SW)) i_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .complete_o(complete_o),
  .error_o(error_o), .step_o(step_o), .updown_o(updown_o), .cntsel_o(cntsel_o));

// File: tb/test_phase_step_seq.sv
`timescale 1ns/1ps
module test_phase_step_seq;
  localparam int  CW = 8, SW = 4, TW = 12;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst = 1, start_i = 0, dir_i = 0, done_i = 1;
  logic [CW-1:0] steps_i = '0;
  logic [SW-1:0] sel_i = '0;
  logic [TW-1:0] timeout_i = 12'd40;
  logic busy_o, complete_o, error_o, step_o, updown_o;
  logic [SW-1:0] cntsel_o;

  int total = 0, bad = 0;
  int model_steps = 0, cap_bad = 0, width_bad = 0, gap_bad = 0;
  bit model_on = 1, model_rise = 1;
  int low_ns = 30;
  logic exp_dir; logic [SW-1:0] exp_sel;

  always #(PERIOD/2) clk = ~clk;

  phase_step_seq #(.CW(CW), .SW(SW), .TW(TW)) i_phase_step_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .steps_i(steps_i), .dir_i(dir_i),
    .sel_i(sel_i), .timeout_i(timeout_i), .busy_o(busy_o), .complete_o(complete_o),
    .error_o(error_o), .step_o(step_o), .updown_o(updown_o), .cntsel_o(cntsel_o),
    .done_i(done_i));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // PLL model: latch on falling edge, capture controls two rising edges later, then done low/high
  initial forever begin
    @(negedge clk);
    if (step_o === 1'b1 && model_on) begin
      @(posedge clk); @(posedge clk);
      if (updown_o !== exp_dir || cntsel_o !== exp_sel) cap_bad++;
      model_steps++;
      #1 done_i = 0;
      if (model_rise) begin
        #(low_ns * 1ns) done_i = 1;
        if (step_o !== 1'b0) gap_bad++;
      end
    end
  end

  // step pulse width monitor (R3)
  initial begin
    int run = 0;
    forever begin
      @(negedge clk);
      if (step_o === 1'b1) run++;
      else begin
        if (run != 0 && run != 2) width_bad++;
        run = 0;
      end
    end
  end

  task automatic pulse_start(input int n, input logic d, input logic [SW-1:0] s);
    steps_i = CW'(n); dir_i = d; sel_i = s;
    exp_dir = d; exp_sel = s;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_end(output int completes);
    completes = 0;
    for (int i = 0; i < 5000; i++) begin
      if (complete_o) completes++;
      if (!busy_o) break;
      @(negedge clk);
    end
    if (complete_o === 1'b1 && completes == 0) completes++;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(busy_o === 0 && complete_o === 0 && error_o === 0 && step_o === 0,
          "R1 reset outputs", {busy_o, complete_o, error_o, step_o}, 0);
  endtask

  task automatic t_run(input int n, input logic d, input logic [SW-1:0] s, input int lown, input string req);
    int c;
    low_ns = lown; model_steps = 0;
    pulse_start(n, d, s);
    check(busy_o === 1, {req, " busy after start"}, busy_o, 1);
    wait_end(c);
    check(c == 1 && busy_o === 0, {req, " single complete at end"}, c, 1);
    check(model_steps == n, {req, " step count"}, model_steps, n);
    check(error_o === 0, {req, " no error"}, error_o, 0);
    @(negedge clk);
    check(complete_o === 0, "R2 complete one cycle", complete_o, 0);
  endtask

  task automatic t_busy_start;
    int c;
    low_ns = 20; model_steps = 0;
    pulse_start(3, 1, 4'h2);
    repeat (6) @(negedge clk);
    steps_i = 8'd9; start_i = 1;
    @(negedge clk); start_i = 0;
    wait_end(c);
    check(model_steps == 3, "R8 start while busy ignored", model_steps, 3);
    check(c == 1, "R8 one complete", c, 1);
    @(negedge clk);
  endtask

  task automatic t_zero;
    model_steps = 0;
    pulse_start(0, 0, 4'h1);
    check(complete_o === 1 && busy_o === 0, "R9 zero count completes", {complete_o, busy_o}, 2);
    @(negedge clk);
    check(complete_o === 0 && model_steps == 0, "R9 no step", model_steps, 0);
  endtask

  task automatic t_back_to_back;
    int c = 0;
    low_ns = 25; model_steps = 0;
    pulse_start(2, 0, 4'h5);
    for (int i = 0; i < 5000; i++) begin
      if (complete_o) break;
      @(negedge clk);
    end
    check(complete_o === 1, "R10 first run complete", complete_o, 1);
    pulse_start(3, 1, 4'hA);
    check(busy_o === 1, "R10 start in complete cycle accepted", busy_o, 1);
    wait_end(c);
    check(model_steps == 5 && c == 1, "R10 both runs stepped", model_steps, 5);
    @(negedge clk);
  endtask

  task automatic t_timeout_no_fall;
    int c;
    model_on = 0; model_steps = 0; timeout_i = 12'd20;
    pulse_start(3, 1, 4'h3);
    wait_end(c);
    check(error_o === 1 && c == 0, "R7 timeout when done never falls", error_o, 1);
    check(model_steps == 0, "R7 no handshake", model_steps, 0);
    model_on = 1;
    @(negedge clk);
  endtask

  task automatic t_timeout_no_rise;
    int c;
    model_rise = 0; model_steps = 0;
    pulse_start(4, 0, 4'h6);
    wait_end(c);
    check(error_o === 1 && c == 0, "R7 timeout when done stays low", error_o, 1);
    check(model_steps == 1, "R4 no step before done rises", model_steps, 1);
    done_i = 1; model_rise = 1;
    repeat (3) @(negedge clk);
    pulse_start(1, 0, 4'h6);
    check(error_o === 0, "R7 error cleared by start", error_o, 1'b0);
    wait_end(c);
    @(negedge clk);
    timeout_i = 12'd40;
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_run(4, 1, 4'h9, 30, "R2 long done low");
    t_run(40, 0, 4'h3, 2, "R6 brief done low");
    check(cap_bad == 0, "R5 controls captured by PLL", cap_bad, 0);
    t_busy_start();
    t_zero();
    t_back_to_back();
    t_timeout_no_fall();
    t_timeout_no_rise();
    check(cap_bad == 0, "R5 controls after all runs", cap_bad, 0);
    check(width_bad == 0, "R3 step width two cycles", width_bad, 0);
    check(gap_bad == 0, "R4 step low after handshake", gap_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule